// File: doc/BRIEF.md
# Variable-Frequency Steered Pulse Generator

This block is the clock-counted control path of a resonant power converter. A free-running oscillator alternates between a charge phase and a discharge phase. The charge phase has a programmable length and sets the minimum gap between output pulses. The discharge phase length comes from a frequency command: a larger command gives a shorter discharge phase and so a higher switching rate. Each time the charge phase ends, a one-shot timer starts and an output pulse begins. The pulse ends when the one-shot expires or when the discharge phase ends, whichever comes first. At low command values this gives a constant on-time with a variable off-time. At high command values it gives a variable on-time with an off-time fixed by the deadtime.

A steering stage sends successive pulses alternately to two drive outputs, A then B. An inhibit input holds the whole path in the charge phase and resets the steering, so the first pulse after release always appears on A. An inhibit would typically come from undervoltage lockout or from a latched fault. A separate fault-blank input masks both outputs at the next clock edge, without going through that inhibit path.

Top module: `vfo_pulse_steer`

## Requirements
- R1: While reset is applied both outputs are 0. After reset or inhibit is released, the first output pulse appears on outA. Its first high cycle comes L+1 clock edges after the last edge that saw reset or inhibit active, where L is the charge length.
- R2: The charge length L is `deadCnt` clock cycles, and a `deadCnt` of 0 counts as 1. Both outputs stay low for the whole charge phase, so consecutive pulses start L+Ld cycles apart, where Ld is the discharge length.
- R3: When the one-shot length Lo is shorter than Ld, every pulse is exactly Lo cycles wide (constant on-time).
- R4: When Lo is equal to or longer than Ld, every pulse is Ld cycles wide and the gap between pulses is exactly L cycles (constant off-time).
- R5: The discharge length Ld is (2^CNT_W − 1) minus the clamped command, and a result of 0 counts as 1. A higher command therefore gives a shorter Ld. At the default width Ld ranges from 1 to 65535 cycles.
- R6: The command is first raised to `cmdMin` and then lowered to `cmdMax`. If the two limits cross, `cmdMax` wins.
- R7: The discharge length is taken from the command when a discharge phase starts. A command change during that phase only affects later phases.
- R8: Successive pulses alternate between outputs: A, B, A, B, and so on.
- R9: outA and outB are never high in the same cycle.
- R10: If `faultBlank` is high at a clock edge, both outputs are 0 after that edge. The oscillator and the steering keep running, so a pulse that is masked still uses up its turn (A, masked B, then A).
- R11: An `inhibit` seen at a clock edge forces both outputs to 0 from the second edge onward. No pulses appear while inhibit is held, and the steering is reset so that output A comes next.
- R12: The one-shot length Lo is `osCnt` cycles, and an `osCnt` of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inhibit | input | 1 | Holds the oscillator in the charge phase and resets the steering |
| faultBlank | input | 1 | Masks both outputs from the next edge |
| freqCmd | input | CNT_W | Frequency command; a higher value gives a shorter discharge phase |
| cmdMin | input | CNT_W | Lower clamp limit for the command |
| cmdMax | input | CNT_W | Upper clamp limit for the command (wins over cmdMin) |
| deadCnt | input | CNT_W | Charge-phase length in cycles |
| osCnt | input | CNT_W | One-shot length in cycles |
| outA | output | 1 | Registered drive output A |
| outB | output | 1 | Registered drive output B |

## Verification
The one-shot expiry and the end of the discharge phase can both try to end the same pulse. The bench sets Lo equal to Ld so that both happen on one edge. It then expects a pulse exactly Ld wide with an off-time of L, which is the same result as in the strict retrigger case.

A fault blank can also coincide with the live pulse. The bench raises it in the first high cycle of a pulse and requires the output to be low at the very next edge. It then checks that the following pulse still goes to the other output, because the masked pulse used up its turn in the steering.

// File: rtl/vfo_pkg.sv
package vfo_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic {
    PH_CHARGE    = 1'b0,
    PH_DISCHARGE = 1'b1
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // inhibit: return to start of charge
    logic startDis;  // charge finished, begin discharge and one-shot
    logic endDis;    // discharge finished, begin charge
    logic inDis;     // currently in discharge phase
  } vfo_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic chgDone;   // last cycle of charge phase
    logic disDone;   // last cycle of discharge phase
    logic osRun;     // one-shot still running
  } vfo_status_t;
endpackage

// File: rtl/vfo_datapath.sv
module vfo_datapath
  import vfo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfo_strobe_t       strobe,
  input  logic [CNT_W-1:0]  freqCmd,
  input  logic [CNT_W-1:0]  cmdMin,
  input  logic [CNT_W-1:0]  cmdMax,
  input  logic [CNT_W-1:0]  deadCnt,
  input  logic [CNT_W-1:0]  osCnt,
  output vfo_status_t       status
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] TOP  = '1;

  logic [CNT_W-1:0] phaseCnt;   // cycles elapsed in current phase
  logic [CNT_W-1:0] disLenQ;    // discharge length captured at phase start
  logic [CNT_W-1:0] osLeft;     // one-shot cycles remaining

  logic [CNT_W-1:0] chargeLen, osLen, cmdLo, cmdClamped, disRaw, disLenNew;

  always_comb begin
    chargeLen  = (deadCnt == ZERO) ? ONE : deadCnt;
    osLen      = (osCnt == ZERO) ? ONE : osCnt;
    cmdLo      = (freqCmd < cmdMin) ? cmdMin : freqCmd;
    cmdClamped = (cmdLo > cmdMax) ? cmdMax : cmdLo;
    disRaw     = TOP - cmdClamped;
    disLenNew  = (disRaw == ZERO) ? ONE : disRaw;
  end

  always_comb begin
    status.chgDone = (phaseCnt >= (chargeLen - ONE));
    status.disDone = (phaseCnt >= (disLenQ - ONE));
    status.osRun   = (osLeft != ZERO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= ZERO;
      disLenQ  <= ONE;
      osLeft   <= ZERO;
    end else if (strobe.restart) begin
      phaseCnt <= ZERO;
      osLeft   <= ZERO;
    end else if (strobe.startDis) begin
      phaseCnt <= ZERO;
      disLenQ  <= disLenNew;
      osLeft   <= osLen;
    end else if (strobe.endDis) begin
      phaseCnt <= ZERO;
      osLeft   <= ZERO;
    end else begin
      phaseCnt <= phaseCnt + ONE;
      if (strobe.inDis && osLeft != ZERO) osLeft <= osLeft - ONE;
    end
  end
endmodule

// File: rtl/vfo_ctrl.sv
module vfo_ctrl
  import vfo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inhibit,
  input  logic        faultBlank,
  input  vfo_status_t status,
  output vfo_strobe_t strobe,
  output logic        outA,
  output logic        outB
);
  timeunit 1ns; timeprecision 100ps;

  phase_e phase;
  logic   toB;      // destination of the current pulse; reset to 1 so the first toggle selects A
  logic   ton;

  always_comb begin
    strobe.restart  = inhibit;
    strobe.startDis = !inhibit && (phase == PH_CHARGE) && status.chgDone;
    strobe.endDis   = !inhibit && (phase == PH_DISCHARGE) && status.disDone;
    strobe.inDis    = (phase == PH_DISCHARGE);
    ton             = (phase == PH_DISCHARGE) && status.osRun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_CHARGE;
      toB   <= 1'b1;
      outA  <= 1'b0;
      outB  <= 1'b0;
    end else begin
      outA <= ton && !toB && !faultBlank;
      outB <= ton &&  toB && !faultBlank;
      if (inhibit) begin
        phase <= PH_CHARGE;
        toB   <= 1'b1;
      end else if (strobe.startDis) begin
        phase <= PH_DISCHARGE;
        toB   <= ~toB;
      end else if (strobe.endDis) begin
        phase <= PH_CHARGE;
      end
    end
  end
endmodule

// File: rtl/vfo_pulse_steer.sv
module vfo_pulse_steer
  import vfo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inhibit,
  input  logic             faultBlank,
  input  logic [CNT_W-1:0] freqCmd,
  input  logic [CNT_W-1:0] cmdMin,
  input  logic [CNT_W-1:0] cmdMax,
  input  logic [CNT_W-1:0] deadCnt,
  input  logic [CNT_W-1:0] osCnt,
  output logic             outA,
  output logic             outB
);
  timeunit 1ns; timeprecision 100ps;

  vfo_strobe_t strobe;
  vfo_status_t status;

  vfo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inhibit(inhibit), .faultBlank(faultBlank),
    .status(status), .strobe(strobe), .outA(outA), .outB(outB)
  );

  vfo_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .freqCmd(freqCmd), .cmdMin(cmdMin), .cmdMax(cmdMax),
    .deadCnt(deadCnt), .osCnt(osCnt), .status(status)
  );
endmodule

// File: rtl/vfo_pulse_steer_chk.sv
module vfo_pulse_steer_chk (
  input logic clk,
  input logic rstN,
  input logic inhibit,
  input logic faultBlank,
  input logic outA,
  input logic outB
);
  timeunit 1ns; timeprecision 100ps;

  // set by inhibit, cleared once any pulse (or masking) is seen
  logic armA;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            armA <= 1'b1;
    else if (inhibit)                     armA <= 1'b1;
    else if (outA || outB || faultBlank)  armA <= 1'b0;
  end

  assert_mutex_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB));

  assert_fault_blank_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultBlank |=> (!outA && !outB));

  assert_inhibit_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |-> ##2 (!outA && !outB));

  // R1: first pulse after reset or inhibit goes to A
  assert_first_on_a_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outB) && !$past(inhibit)) |-> !armA);
endmodule

bind vfo_pulse_steer vfo_pulse_steer_chk u_chk (
  .clk(clk), .rstN(rstN), .inhibit(inhibit), .faultBlank(faultBlank),
  .outA(outA), .outB(outB)
);

// File: tb/tb_vfo_pulse_steer.sv
module tb_vfo_pulse_steer;
  timeunit 1ns; timeprecision 100ps;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN, inhibit, faultBlank;
  logic [W-1:0] freqCmd, cmdMin, cmdMax, deadCnt, osCnt;
  logic outA, outB;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int evStart [0:31];
  int evWidth [0:31];
  bit evIsB   [0:31];
  int evCnt = 0;
  bit prevA = 0, prevB = 0;

  vfo_pulse_steer #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .inhibit(inhibit), .faultBlank(faultBlank),
    .freqCmd(freqCmd), .cmdMin(cmdMin), .cmdMax(cmdMax),
    .deadCnt(deadCnt), .osCnt(osCnt), .outA(outA), .outB(outB)
  );

  always #2.5 clk = ~clk;   // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // pulse logger, sampled 1 ns after each rising edge
  always begin
    @(posedge clk); #1;
    if ((outA && !prevA) || (outB && !prevB)) begin
      if (evCnt < 32) begin
        evIsB[evCnt] = outB; evStart[evCnt] = cyc; evWidth[evCnt] = 1; evCnt++;
      end
    end else if ((outA || outB) && evCnt > 0) begin
      evWidth[evCnt-1]++;
    end
    prevA = outA; prevB = outB;
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  task automatic configure(input int d, input int lo, input int cmd, input int cmn, input int cmx);
    @(posedge clk); #1;
    inhibit = 1'b1; faultBlank = 1'b0;
    deadCnt = W'(d); osCnt = W'(lo); freqCmd = W'(cmd); cmdMin = W'(cmn); cmdMax = W'(cmx);
    repeat (3) begin @(posedge clk); #1; end
    evCnt = 0;
  endtask

  task automatic releaseRun(output int t0);
    inhibit = 1'b0;
    t0 = cyc;
  endtask

  // n pulses alternating from A, first at t0+L+1, spaced by period
  task automatic expectTrain(input string req, input int t0, input int l, input int width,
                             input int period, input int n);
    waitUntil(t0 + l + 1 + (n-1)*period + width + 2);
    checkEq(req, "pulse count", (evCnt >= n) ? n : evCnt, n);
    for (int k = 0; k < n; k++) begin
      if (k < evCnt) begin
        checkEq(req, $sformatf("start of pulse %0d", k), evStart[k], t0 + l + 1 + k*period);
        checkEq(req, $sformatf("width of pulse %0d", k), evWidth[k], width);
        checkEq(req, $sformatf("output of pulse %0d (0=A)", k), int'(evIsB[k]), k % 2);
      end
    end
  endtask

  // R1 R3 R8: reset state, then constant on-time train
  task automatic testResetOnTime();
    int t0;
    rstN = 1'b0; inhibit = 1'b0; faultBlank = 1'b0;
    deadCnt = 3; osCnt = 4; freqCmd = 16'd65525; cmdMin = 0; cmdMax = 16'hFFFF;
    repeat (3) begin @(posedge clk); #1; end
    checkEq("R1", "outA in reset", int'(outA), 0);
    checkEq("R1", "outB in reset", int'(outB), 0);
    evCnt = 0;
    rstN = 1'b1; t0 = cyc;
    expectTrain("R1/R3/R8", t0, 3, 4, 13, 3);
  endtask

  // R4: retrigger, off-time equals deadtime; also Lo == Ld corner
  task automatic testRetrigger();
    int t0;
    configure(3, 20, 65529, 0, 65535);      // Ld = 6
    releaseRun(t0);
    expectTrain("R4", t0, 3, 6, 9, 3);
    configure(3, 6, 65529, 0, 65535);       // Lo == Ld
    releaseRun(t0);
    expectTrain("R4 equal", t0, 3, 6, 9, 3);
  endtask

  // R2: deadtime zero acts as one cycle
  task automatic testDeadZero();
    int t0;
    configure(0, 2, 65531, 0, 65535);       // L = 1, Ld = 4
    releaseRun(t0);
    expectTrain("R2", t0, 1, 2, 5, 3);
  endtask

  // R12: one-shot zero acts as one cycle
  task automatic testOneShotZero();
    int t0;
    configure(2, 0, 65530, 0, 65535);       // Ld = 5
    releaseRun(t0);
    expectTrain("R12", t0, 2, 1, 7, 2);
  endtask

  // R5 R6: clamps and discharge length mapping
  task automatic testClamp();
    int t0;
    configure(2, 50, 100, 65530, 65535);    // raised to 65530 -> Ld 5
    releaseRun(t0);
    expectTrain("R6 min", t0, 2, 5, 7, 2);
    configure(2, 50, 65535, 0, 65532);      // lowered to 65532 -> Ld 3
    releaseRun(t0);
    expectTrain("R5/R6 max", t0, 2, 3, 5, 2);
    configure(2, 50, 65535, 65534, 65530);  // crossed limits, max wins -> Ld 5
    releaseRun(t0);
    expectTrain("R6 crossed", t0, 2, 5, 7, 2);
    configure(2, 50, 65535, 0, 65535);      // Ld 0 -> 1
    releaseRun(t0);
    expectTrain("R5 zero", t0, 2, 1, 3, 3);
  endtask

  // R7: command change mid-discharge affects next phase only
  task automatic testCmdLatch();
    int t0, s0;
    configure(2, 100, 65515, 0, 65535);     // Ld 20
    releaseRun(t0);
    s0 = t0 + 3;
    waitUntil(s0 + 5);
    freqCmd = 16'd65531;                    // Ld 4
    waitUntil(s0 + 22 + 6 + 4 + 2);
    checkEq("R7", "pulse count", (evCnt >= 3) ? 3 : evCnt, 3);
    if (evCnt >= 3) begin
      checkEq("R7", "width in progress", evWidth[0], 20);
      checkEq("R7", "second start", evStart[1], s0 + 22);
      checkEq("R7", "second width", evWidth[1], 4);
      checkEq("R7", "third start", evStart[2], s0 + 28);
    end
  endtask

  // R10: fault blank masks, steering continues
  task automatic testFault();
    int t0, s0;
    configure(2, 3, 65530, 0, 65535);       // period 7, width 3
    releaseRun(t0);
    s0 = t0 + 3;
    waitUntil(s0 + 5);
    faultBlank = 1'b1;
    waitUntil(s0 + 8);
    checkEq("R10", "outB while blanked", int'(outB), 0);
    waitUntil(s0 + 12);
    faultBlank = 1'b0;
    waitUntil(s0 + 14);
    checkEq("R10", "outA after masked B", int'(outA), 1);
    faultBlank = 1'b1;
    waitUntil(s0 + 15);
    checkEq("R10", "outA one edge after blank", int'(outA), 0);
    faultBlank = 1'b0;
    waitUntil(s0 + 21);
    checkEq("R10", "outB next turn", int'(outB), 1);
    waitUntil(s0 + 25);
    checkEq("R10", "logged pulses", (evCnt >= 3) ? 3 : evCnt, 3);
    if (evCnt >= 3) begin
      checkEq("R10", "cut pulse width", evWidth[1], 1);
      checkEq("R10", "cut pulse on A", int'(evIsB[1]), 0);
    end
  endtask

  // R11: inhibit silences and resets steering
  task automatic testInhibit();
    int t0, s0, t1;
    configure(2, 3, 65530, 0, 65535);
    releaseRun(t0);
    s0 = t0 + 3;
    waitUntil(s0);
    checkEq("R11", "outA before inhibit", int'(outA), 1);
    inhibit = 1'b1;
    waitUntil(s0 + 2);
    checkEq("R11", "outA two edges after inhibit", int'(outA), 0);
    checkEq("R11", "outB two edges after inhibit", int'(outB), 0);
    waitUntil(s0 + 20);
    checkEq("R11", "no pulses while held", evCnt, 1);
    evCnt = 0;
    releaseRun(t1);
    expectTrain("R11", t1, 2, 3, 7, 2);
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testResetOnTime();
    testRetrigger();
    testDeadZero();
    testOneShotZero();
    testClamp();
    testCmdLatch();
    testFault();
    testInhibit();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule